// File: doc/BRIEF.md
# Comma Word Aligner with Dual Half-Rate Byte Clocks

This block sits behind a clock-recovery stage. It takes one recovered bit per bit-clock edge and looks for the 7-bit comma that opens a K28.5 character. It then places the 10-bit word boundary so that the comma starts a word. Each delivered word comes with one of two complementary byte clocks, and each clock runs at half the word rate. Even-numbered words go with `bclk_b` and odd-numbered words with `bclk_a`. A word carrying an aligned comma is always delivered on a rising `bclk_b`. During that word the sync flag is high.

Alignment works only while `sync_en` is high. A comma that sits off the current boundary moves the boundary at once, and the partly built word is discarded. A comma that already sits on the boundary but would be delivered on `bclk_a` is dropped instead. In that case both byte clocks hold their levels for one extra word time, which swaps which word each clock carries. Afterwards the following commas arrive on `bclk_b`.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_n` is low, `rx_word` is zero and `sync_flag`, `bclk_a` and `bclk_b` are all low. Both clocks stay low until the first word is delivered.
- R2: Each delivered word holds the last 10 received bits, and the earliest of them is on `rx_word[0]`. Without realignment, one word is delivered every 10 bit clocks, and the first word after reset holds bits 1 to 10.
- R3: While `sync_en` is low, the word boundary and the clock phase never change, whatever comma patterns arrive, and `sync_flag` stays low.
- R4: While `sync_en` is high, a comma (received bits 0,0,1,1,1,1,1, that is `rx_word[6:0]` = 7'b1111100) whose first bit is not on the current boundary moves the boundary so the comma starts a word. The word being assembled at that moment is discarded.
- R5: After the first word, `bclk_a` and `bclk_b` are complements. Every delivered word raises exactly one of them, in alternation. The first word after reset raises `bclk_b`.
- R6: `sync_flag` is high for exactly the delivered word whose `rx_word[6:0]` is the comma, when that word raises `bclk_b` and `sync_en` is high. It drops at the next word boundary.
- R7: While `sync_en` is high, a comma that lands on the boundary while `bclk_b` is high (so its word would raise `bclk_a`) is not delivered. Both clocks hold for 20 bit clocks, and then the next word raises `bclk_a`. No clock edge is ever more than 12 bit clocks after a realignment.
- R8: A word appears on `rx_word` at the bit-clock edge that samples its last bit, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial data bit |
| sync_en | input | 1 | High to allow comma search and boundary moves |
| rx_word | output | 10 | Aligned parallel word, first received bit in bit 0 |
| bclk_a | output | 1 | Half-rate byte clock for odd words |
| bclk_b | output | 1 | Half-rate byte clock for even words and comma words |
| sync_flag | output | 1 | High for the word that starts with an aligned comma |

## Verification
The boundary counter and the clock-phase bit cannot be read directly, but an error in either shows up within one word time. An off-by-one boundary rotates the bits of every following word. A wrong phase bit puts the comma word on `bclk_a`, or makes a clock hold where it should toggle. A stuck drop request shows as a gap longer than 20 bit clocks between clock edges. The bench runs a per-bit model of the ports built from the requirements and compares against it after every bit. It also measures the longest gap between byte-clock edges during a forced phase flip.

// File: rtl/cwa_pkg.sv
`timescale 1ns/1ps
package cwa_pkg;
   // Default word and comma geometry; bit i of the mark is the i-th received bit.
   localparam int unsigned    CWA_WORD_W = 10;
   localparam int unsigned    CWA_MARK_W = 7;
   localparam logic [6:0]     CWA_MARK   = 7'b1111100;

   // What the boundary controller asks the output stage to do at a bit edge.
   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_TAKE = 2'd1,
      SLOT_DROP = 2'd2
   } slot_e;
endpackage

// File: rtl/cwa_bit_window.sv
`timescale 1ns/1ps
module cwa_bit_window #(
   parameter int unsigned       WORD_W = 10,
   parameter int unsigned       MARK_W = 7,
   parameter logic [MARK_W-1:0] MARK   = 7'b1111100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   output logic [WORD_W-1:0] win_nxt,
   output logic              tail_hit,
   output logic              head_hit
);
   localparam int unsigned TAIL_LO = WORD_W - MARK_W;

   logic [WORD_W-1:0] win_q;
   logic [MARK_W-1:0] tail_eq;
   logic [MARK_W-1:0] head_eq;

   // Newest bit enters at the top; the oldest bit of the window sits in bit 0.
   assign win_nxt = {din, win_q[WORD_W-1:1]};

   for (genvar gi = 0; gi < MARK_W; gi++) begin : g_cmp
      assign tail_eq[gi] = (win_nxt[TAIL_LO+gi] == MARK[gi]);
      assign head_eq[gi] = (win_nxt[gi] == MARK[gi]);
   end

   assign tail_hit = &tail_eq;
   assign head_hit = &head_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_nxt;
   end

   // R4: a mark just completed reaches the head of the window TAIL_LO bits later.
   p_mark_travel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tail_hit |-> ##(TAIL_LO) head_hit);
endmodule

// File: rtl/cwa_boundary_ctrl.sv
`timescale 1ns/1ps
module cwa_boundary_ctrl
   import cwa_pkg::*;
#(
   parameter int unsigned WORD_W = 10,
   parameter int unsigned MARK_W = 7
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sync_en,
   input  logic  tail_hit,
   output slot_e slot,
   output logic  phase_b
);
   localparam int unsigned       CNT_W      = $clog2(WORD_W);
   localparam logic [CNT_W-1:0]  LAST       = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0]  MARK_END   = CNT_W'(MARK_W - 1);
   localparam logic [CNT_W-1:0]  AFTER_MARK = CNT_W'(MARK_W);
   localparam int unsigned       HOLD_MAX   = 2*WORD_W - MARK_W;
   localparam int unsigned       HOLD_W     = $clog2(HOLD_MAX + 2);

   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              ph_q, ph_d;
   logic              skip_q, skip_d;
   logic              at_bnd, take, in_place, realign;
   logic [HOLD_W-1:0] hold_q;

   always_comb begin
      at_bnd   = (cnt_q == LAST);
      take     = at_bnd & ~skip_q;
      ph_d     = take ? ~ph_q : ph_q;
      // A mark is in place when it ends on bit MARK_END and its word will raise clock B.
      in_place = (cnt_q == MARK_END) & ~ph_q;
      realign  = sync_en & tail_hit & ~in_place;
      if (realign)     cnt_d = AFTER_MARK;
      else if (at_bnd) cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
      if (realign)     skip_d = ph_d;
      else if (at_bnd) skip_d = 1'b0;
      else             skip_d = skip_q;
      if (take)        slot = SLOT_TAKE;
      else if (at_bnd) slot = SLOT_DROP;
      else             slot = SLOT_NONE;
   end

   assign phase_b = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         ph_q   <= ph_d;
         skip_q <= skip_d;
      end
   end

   // Bit clocks since the last delivered word or boundary move.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold_q <= '0;
      else if (take || realign)  hold_q <= '0;
      else if (hold_q != '1)     hold_q <= hold_q + 1'b1;
   end

   // R3: with alignment off the counter only steps by one, modulo the word width.
   p_free_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |=> cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1));

   // R7: a dropped word only ever happens while clock B is high.
   p_drop_under_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_DROP) |-> phase_b);

   // R7: the hold after a move never runs past the bound.
   p_hold_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q < HOLD_W'(HOLD_MAX));
endmodule

// File: rtl/cwa_word_out.sv
`timescale 1ns/1ps
module cwa_word_out
   import cwa_pkg::*;
#(
   parameter int unsigned       WORD_W = 10,
   parameter int unsigned       MARK_W = 7,
   parameter logic [MARK_W-1:0] MARK   = 7'b1111100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slot_e             slot,
   input  logic              phase_b,
   input  logic              sync_en,
   input  logic              head_hit,
   input  logic [WORD_W-1:0] win_nxt,
   output logic [WORD_W-1:0] data,
   output logic              sync_flag,
   output logic              bclk_a,
   output logic              bclk_b
);
   logic              live_q;
   logic              flag_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         flag_q <= 1'b0;
         data_q <= '0;
      end else if (slot == SLOT_TAKE) begin
         live_q <= 1'b1;
         data_q <= win_nxt;
         // phase_b is still the old phase here: low means this word raises clock B.
         flag_q <= sync_en & head_hit & ~phase_b;
      end else if (slot == SLOT_DROP) begin
         flag_q <= 1'b0;
      end
   end

   assign data      = data_q;
   assign sync_flag = flag_q;
   assign bclk_b    = live_q & phase_b;
   assign bclk_a    = live_q & ~phase_b;

   p_flag_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_flag |-> (data[MARK_W-1:0] == MARK));

   p_flag_on_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_flag |-> bclk_b);

   p_edge_per_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bclk_a) || $rose(bclk_b)) |-> ($past(slot) == SLOT_TAKE));

   p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_DROP) |=> ($stable(data) && $stable(bclk_a) && $stable(bclk_b)));
endmodule

// File: rtl/comma_word_aligner.sv
`timescale 1ns/1ps
module comma_word_aligner
   import cwa_pkg::*;
#(
   parameter int unsigned       WORD_W = CWA_WORD_W,
   parameter int unsigned       MARK_W = CWA_MARK_W,
   parameter logic [MARK_W-1:0] MARK   = CWA_MARK
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              sync_en,
   output logic [WORD_W-1:0] rx_word,
   output logic              bclk_a,
   output logic              bclk_b,
   output logic              sync_flag
);
   if (MARK_W < 2 || MARK_W >= WORD_W) begin : g_bad_geometry
      $error("comma_word_aligner: MARK_W must be at least 2 and below WORD_W");
   end
   if (WORD_W < 3) begin : g_bad_width
      $error("comma_word_aligner: WORD_W must be at least 3");
   end

   logic [WORD_W-1:0] win_nxt;
   logic              tail_hit;
   logic              head_hit;
   slot_e             slot;
   logic              phase_b;

   cwa_bit_window #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK(MARK)) u_window (
      .clk      (clk_bit),
      .rst_n    (rst_n),
      .din      (ser_in),
      .win_nxt  (win_nxt),
      .tail_hit (tail_hit),
      .head_hit (head_hit)
   );

   cwa_boundary_ctrl #(.WORD_W(WORD_W), .MARK_W(MARK_W)) u_ctrl (
      .clk      (clk_bit),
      .rst_n    (rst_n),
      .sync_en  (sync_en),
      .tail_hit (tail_hit),
      .slot     (slot),
      .phase_b  (phase_b)
   );

   cwa_word_out #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK(MARK)) u_out (
      .clk       (clk_bit),
      .rst_n     (rst_n),
      .slot      (slot),
      .phase_b   (phase_b),
      .sync_en   (sync_en),
      .head_hit  (head_hit),
      .win_nxt   (win_nxt),
      .data      (rx_word),
      .sync_flag (sync_flag),
      .bclk_a    (bclk_a),
      .bclk_b    (bclk_b)
   );

   // R1: the byte clocks are never high together.
   p_clk_excl_r1: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !(bclk_a && bclk_b));
endmodule

// File: tb/comma_word_aligner_tb.sv
`timescale 1ns/1ps
module comma_word_aligner_tb;
   localparam bit [9:0] K_CHAR = 10'b0101111100;  // bit i = i-th received bit
   localparam bit [9:0] D_CHAR = 10'b1010110110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       sync_en = 1'b0;
   logic [9:0] rx_word;
   logic       bclk_a, bclk_b, sync_flag;

   always #2 clk = ~clk;

   comma_word_aligner u_dut (
      .clk_bit(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_en(sync_en),
      .rx_word(rx_word), .bclk_a(bclk_a), .bclk_b(bclk_b), .sync_flag(sync_flag)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // Port-level reference state, built from the requirements.
   int       m_cnt;
   bit       m_ph, m_skip, m_live, m_flag, m_realign;
   bit [9:0] m_win, m_word;

   // Clock-edge bookkeeping.
   int gap = 0;
   int since_edge = 0;
   int iv_max = 0;
   int flags = 0;
   bit pa = 0, pb = 0;

   function automatic bit mark_at(bit [9:0] v, int lo);
      return v[lo+:7] == 7'b1111100;
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_ph = 0; m_skip = 0; m_live = 0; m_flag = 0;
      m_realign = 0; m_win = '0; m_word = '0;
   endtask

   task automatic model_step(bit d, bit en);
      bit [9:0] nx;
      bit bnd, take, ph_new, inplace;
      nx = {d, m_win[9:1]};
      bnd = (m_cnt == 9);
      take = bnd && !m_skip;
      ph_new = take ? !m_ph : m_ph;
      inplace = (m_cnt == 6) && !m_ph;
      m_realign = en && mark_at(nx, 3) && !inplace;
      if (take) begin
         m_word = nx;
         m_flag = en && mark_at(nx, 0) && !m_ph;
         m_live = 1;
      end else if (bnd) m_flag = 0;
      if (m_realign) m_skip = ph_new;
      else if (bnd)  m_skip = 0;
      m_cnt = m_realign ? 7 : (bnd ? 0 : m_cnt + 1);
      m_ph = ph_new;
      m_win = nx;
   endtask

   task automatic step(bit d, bit en);
      ser_in = d;
      sync_en = en;
      model_step(d, en);
      @(posedge clk);
      @(negedge clk);
      check(rx_word == m_word, en ? "R4" : "R3", "word", rx_word, m_word);
      check(sync_flag == m_flag, "R6", "sync flag", sync_flag, m_flag);
      check(bclk_a == (m_live && !m_ph) && bclk_b == (m_live && m_ph), "R5",
            "byte clocks", {bclk_a, bclk_b}, {m_live && !m_ph, m_live && m_ph});
      if (sync_flag) begin
         flags++;
         check(rx_word[6:0] == 7'b1111100, "R6", "flagged word head", rx_word[6:0], 7'b1111100);
      end
      since_edge++;
      if (bclk_a !== pa || bclk_b !== pb) begin
         if (since_edge > iv_max) iv_max = since_edge;
         since_edge = 0;
         gap = 0;
      end else if (m_realign) gap = 0;
      else gap++;
      check(gap <= 12, "R7", "hold after realign", gap, 12);
      pa = bclk_a;
      pb = bclk_b;
   endtask

   task automatic send_word(bit [9:0] w, bit en);
      for (int i = 0; i < 10; i++) step(w[i], en);
   endtask

   initial begin
      bit [9:0] first;
      int       f0;
      bit       en;
      model_reset();
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      check(rx_word == 0 && !sync_flag && !bclk_a && !bclk_b, "R1", "reset state",
            {rx_word, sync_flag, bclk_a, bclk_b}, 0);
      rst_n = 1'b1;

      // R2 / R8: first word after reset, bit order and delivery edge.
      first = 10'b1010001101;
      for (int i = 0; i < 10; i++) begin
         step(first[i], 1'b0);
         if (i == 8) check(rx_word == 0 && !bclk_a && !bclk_b, "R8", "no word before last bit",
                           {rx_word, bclk_a, bclk_b}, 0);
      end
      check(rx_word == first, "R2", "first word bit order", rx_word, first);
      check(bclk_b && !bclk_a, "R5", "first word on bclk_b", {bclk_a, bclk_b}, 2'b01);

      // R3: misaligned commas with alignment off change nothing.
      f0 = flags;
      for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 4; i++) begin send_word(K_CHAR, 1'b0); send_word(D_CHAR, 1'b0); end
      check(flags == f0, "R3", "no flag while disabled", flags - f0, 0);
      check(iv_max == 10, "R3", "word interval unchanged", iv_max, 10);

      // R4 / R6: enable alignment on the same misaligned idle stream.
      f0 = flags;
      for (int i = 0; i < 6; i++) begin send_word(K_CHAR, 1'b1); send_word(D_CHAR, 1'b1); end
      check(flags - f0 >= 4, "R4", "commas aligned and flagged", flags - f0, 4);
      send_word(K_CHAR, 1'b1);
      check(sync_flag && rx_word == K_CHAR && bclk_b, "R6", "comma word on bclk_b",
            {sync_flag, bclk_b, rx_word}, {2'b11, K_CHAR});

      // R7: one extra word puts the next comma under bclk_a; clocks stretch to 20 bits.
      send_word(D_CHAR, 1'b1);
      iv_max = 0;
      f0 = flags;
      send_word(D_CHAR, 1'b1);
      send_word(K_CHAR, 1'b1);
      send_word(D_CHAR, 1'b1);
      check(iv_max == 20, "R7", "stretch on phase flip", iv_max, 20);
      check(flags == f0, "R7", "flipped comma not delivered", flags - f0, 0);
      check(bclk_a && !bclk_b, "R7", "word after stretch on bclk_a", {bclk_a, bclk_b}, 2'b10);
      send_word(K_CHAR, 1'b1);
      check(sync_flag && rx_word == K_CHAR, "R6", "next comma flagged", sync_flag, 1);

      // Constrained random: random bits, inserted commas, toggling enable.
      en = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 199) == 0) en = !en;
         if ($urandom_range(0, 14) == 0) send_word(K_CHAR, en);
         else step(1'($urandom_range(0, 1)), en);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule